// File: doc/BRIEF.md
# Serial Transfer Status and Configuration Lock

This block is the control-side companion of a clocked serial port that moves a run of bytes without software help. It keeps a flag that reads 1 while a transfer is in progress, an enable for bit-error detection, and a sticky bit-error flag. The bit-error flag is raised when the shift engine marks a data-bit period and the synchronized busy handshake input shows the programmed busy level.

Software reaches the block through a single-cycle register write port and a combinational read port. A transfer starts from a start trigger or from a write to the shift-data register. It ends on the shift engine's end-of-transfer pulse, on a stop trigger, or when the interface is disabled. While it runs, the configuration registers are frozen against any write that would change them. Writes that repeat the stored value are still accepted, and buffer-memory writes always pass through. The register map is: 0 mode, 1 status, 2 divisor, 3 address pointer, 4 interval, 5 shift data, 6 trigger, 7 buffer window.

Top module: `serial_xfer_guard`

## Requirements
- R1: After reset every stored register reads 0x00, and `xfer_o` and `berr_o` are 0.
- R2: With the interface enabled (mode bit 7 = 1), a trigger write (address 6) with bit 0 set makes `xfer_o` 1 from the next cycle. An accepted write to the shift-data register (address 5) does the same.
- R3: `xfer_o` returns to 0 on the cycle after any of these: an end-of-transfer pulse, a trigger write with bit 1 set, or a cycle with the stored interface enable at 0. When bits 0 and 1 are both set in the same trigger write, stop wins and `xfer_o` ends up 0.
- R4: While `xfer_o` is 1, a write that would change the mode, divisor, pointer, interval or shift-data register is ignored. The same holds for a write that would change the error-enable bit (status bit 7). Writes equal to the stored value are accepted, and reads keep working.
- R5: A write to address 7 appears on `buf_we_o`/`buf_wdata_o` in the same cycle whether or not a transfer runs.
- R6: With error detection enabled (status bit 7 = 1), a cycle with `bit_stb_i` high and the synchronized busy input equal to the programmed level (mode bit 0) sets `berr_o` on the next cycle. The busy input passes through two flops, so it must have been stable for two edges before the strobe edge.
- R7: `berr_o` is sticky. It clears only on reset, when the stored interface enable is 0, or on a start trigger. A stop trigger or a shift-data write leaves it at 1.
- R8: The error-enable bit is written and acts independently of the busy-input-use bit (mode bit 1). With that bit at 0, detection still works.
- R9: With the error-enable bit at 0, `berr_o` never sets.
- R10: With the stored interface enable at 0, start triggers and shift-data writes leave `xfer_o` at 0.
- R11: The status register reads error-enable in bit 7, `berr_o` in bit 1 and `xfer_o` in bit 0. The trigger and buffer addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write register select |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read register select |
| rd_data_o | output | 8 | Combinational read data |
| busy_i | input | 1 | Asynchronous busy handshake pin |
| bit_stb_i | input | 1 | One-cycle strobe per data bit from the shift engine |
| xfer_done_i | input | 1 | End-of-transfer pulse from the shift engine |
| mode_o | output | 8 | Stored mode register |
| div_o | output | 8 | Stored divisor register |
| aptr_o | output | 8 | Stored address-pointer register |
| ival_o | output | 8 | Stored interval register |
| shift_o | output | 8 | Stored shift-data register |
| xfer_o | output | 1 | Transfer-in-progress flag |
| berr_o | output | 1 | Sticky bit-error flag |
| buf_we_o | output | 1 | Buffer-memory write enable, passed through |
| buf_wdata_o | output | 8 | Buffer-memory write data, passed through |

## Verification
Register writes, triggers and the end-of-transfer pulse act at one clock edge, and their effect is visible on the next cycle. A changed busy level needs two edges in the synchronizer, so the strobe edge that samples it must come at least two edges later. The bench therefore holds busy one edge too short on purpose and expects no error. Disabling the interface takes one edge to store the enable and a second edge to clear the flags. The bench idles one extra cycle before that check. Every expected item is compared at the falling edge of the cycle in which it is due, and buffer pass-through is compared inside the write cycle itself.

// File: rtl/sxg_pkg.sv
package sxg_pkg;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        REG_MODE  = 3'd0,
        REG_STAT  = 3'd1,
        REG_DIV   = 3'd2,
        REG_APTR  = 3'd3,
        REG_IVAL  = 3'd4,
        REG_SHIFT = 3'd5,
        REG_TRIG  = 3'd6,
        REG_BUF   = 3'd7
    } reg_sel_e;

    // Bit positions within the 8-bit registers
    localparam int MODE_EN_BIT    = 7;
    localparam int MODE_BUSE_BIT  = 1;
    localparam int MODE_LVL_BIT   = 0;
    localparam int STAT_ERREN_BIT = 7;
    localparam int STAT_BERR_BIT  = 1;
    localparam int STAT_XFER_BIT  = 0;
    localparam int TRIG_START_BIT = 0;
    localparam int TRIG_STOP_BIT  = 1;

endpackage

// File: rtl/sxg_busy_sync.sv
module sxg_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic busy_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], busy_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign busy_o = sh_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/sxg_cfg_regs.sv
module sxg_cfg_regs
    import sxg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              lock_i,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] div_o,
    output logic [DATA_W-1:0] aptr_o,
    output logic [DATA_W-1:0] ival_o,
    output logic [DATA_W-1:0] shift_o,
    output logic              err_en_o,
    output logic              shift_wr_o,
    output logic              start_o,
    output logic              stop_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mode;
        logic [DATA_W-1:0] div;
        logic [DATA_W-1:0] aptr;
        logic [DATA_W-1:0] ival;
        logic [DATA_W-1:0] shift;
        logic              err_en;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    reg_sel_e sel;

    // A locked register still takes a write that repeats its value
    function automatic logic take(input logic lock, input logic [DATA_W-1:0] nv,
                                  input logic [DATA_W-1:0] ov);
        return !lock || (nv == ov);
    endfunction

    always_comb begin
        sel        = reg_sel_e'(wr_addr_i);
        cfg_d      = cfg_q;
        shift_wr_o = 1'b0;
        start_o    = 1'b0;
        stop_o     = 1'b0;
        if (wr_en_i) begin
            case (sel)
                REG_MODE:  if (take(lock_i, wr_data_i, cfg_q.mode)) cfg_d.mode = wr_data_i;
                REG_STAT:  if (!lock_i || (wr_data_i[STAT_ERREN_BIT] == cfg_q.err_en))
                               cfg_d.err_en = wr_data_i[STAT_ERREN_BIT];
                REG_DIV:   if (take(lock_i, wr_data_i, cfg_q.div))  cfg_d.div  = wr_data_i;
                REG_APTR:  if (take(lock_i, wr_data_i, cfg_q.aptr)) cfg_d.aptr = wr_data_i;
                REG_IVAL:  if (take(lock_i, wr_data_i, cfg_q.ival)) cfg_d.ival = wr_data_i;
                REG_SHIFT: if (take(lock_i, wr_data_i, cfg_q.shift)) begin
                               cfg_d.shift = wr_data_i;
                               shift_wr_o  = 1'b1;
                           end
                REG_TRIG:  begin
                               start_o = wr_data_i[TRIG_START_BIT];
                               stop_o  = wr_data_i[TRIG_STOP_BIT];
                           end
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode_o   = cfg_q.mode;
    assign div_o    = cfg_q.div;
    assign aptr_o   = cfg_q.aptr;
    assign ival_o   = cfg_q.ival;
    assign shift_o  = cfg_q.shift;
    assign err_en_o = cfg_q.err_en;

    assert_div_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && wr_en_i && wr_addr_i == REG_DIV && wr_data_i != cfg_q.div)
        |=> $stable(cfg_q.div));

    assert_mode_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && wr_en_i && wr_addr_i == REG_MODE && wr_data_i != cfg_q.mode)
        |=> $stable(cfg_q.mode));
endmodule

// File: rtl/sxg_status.sv
module sxg_status (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic shift_wr_i,
    input  logic done_i,
    input  logic err_en_i,
    input  logic bit_stb_i,
    input  logic busy_s_i,
    input  logic busy_lvl_i,
    output logic xfer_o,
    output logic berr_o
);
    typedef struct packed {
        logic xfer;
        logic berr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Every clear condition outranks every set condition
        if (!en_i || stop_i || done_i)      st_d.xfer = 1'b0;
        else if (start_i || shift_wr_i)     st_d.xfer = 1'b1;

        if (!en_i || start_i)               st_d.berr = 1'b0;
        else if (err_en_i && bit_stb_i && (busy_s_i == busy_lvl_i))
                                            st_d.berr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign xfer_o = st_q.xfer;
    assign berr_o = st_q.berr;

    assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && en_i && !stop_i && !done_i) |=> st_q.xfer);

    assert_stop_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !st_q.xfer);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.berr && en_i && !start_i) |=> st_q.berr);

    assert_start_clears_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !st_q.berr);

    assert_no_err_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.berr && !err_en_i) |=> !st_q.berr);

    assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!st_q.xfer && !st_q.berr));
endmodule

// File: rtl/serial_xfer_guard.sv
module serial_xfer_guard
    import sxg_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SEL_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              busy_i,
    input  logic              bit_stb_i,
    input  logic              xfer_done_i,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] div_o,
    output logic [DATA_W-1:0] aptr_o,
    output logic [DATA_W-1:0] ival_o,
    output logic [DATA_W-1:0] shift_o,
    output logic              xfer_o,
    output logic              berr_o,
    output logic              buf_we_o,
    output logic [DATA_W-1:0] buf_wdata_o
);
    logic err_en, shift_wr, start, stop, busy_s;

    sxg_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_i),
        .busy_o (busy_s)
    );

    sxg_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .lock_i     (xfer_o),
        .mode_o     (mode_o),
        .div_o      (div_o),
        .aptr_o     (aptr_o),
        .ival_o     (ival_o),
        .shift_o    (shift_o),
        .err_en_o   (err_en),
        .shift_wr_o (shift_wr),
        .start_o    (start),
        .stop_o     (stop)
    );

    sxg_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mode_o[MODE_EN_BIT]),
        .start_i    (start),
        .stop_i     (stop),
        .shift_wr_i (shift_wr),
        .done_i     (xfer_done_i),
        .err_en_i   (err_en),
        .bit_stb_i  (bit_stb_i),
        .busy_s_i   (busy_s),
        .busy_lvl_i (mode_o[MODE_LVL_BIT]),
        .xfer_o     (xfer_o),
        .berr_o     (berr_o)
    );

    // Buffer memory writes are never subject to the lock
    assign buf_we_o    = wr_en_i && (wr_addr_i == REG_BUF);
    assign buf_wdata_o = wr_data_i;

    always_comb begin
        rd_data_o = '0;
        case (reg_sel_e'(rd_addr_i))
            REG_MODE:  rd_data_o = mode_o;
            REG_STAT:  begin
                           rd_data_o[STAT_ERREN_BIT] = err_en;
                           rd_data_o[STAT_BERR_BIT]  = berr_o;
                           rd_data_o[STAT_XFER_BIT]  = xfer_o;
                       end
            REG_DIV:   rd_data_o = div_o;
            REG_APTR:  rd_data_o = aptr_o;
            REG_IVAL:  rd_data_o = ival_o;
            REG_SHIFT: rd_data_o = shift_o;
            default:   rd_data_o = '0;
        endcase
    end

    assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done_i |=> !xfer_o);

    assert_shift_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_o && wr_en_i && wr_addr_i == REG_SHIFT && wr_data_i != shift_o)
        |=> $stable(shift_o));
endmodule

// File: tb/sim_serial_xfer_guard.sv
`timescale 1ns/1ps
module sim_serial_xfer_guard;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic       busy = 1'b1;
    logic       bit_stb = 1'b0;
    logic       done = 1'b0;
    logic [7:0] rd_data_o, mode_o, div_o, aptr_o, ival_o, shift_o, buf_wdata_o;
    logic       xfer_o, berr_o, buf_we_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    serial_xfer_guard u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data_o),
        .busy_i(busy), .bit_stb_i(bit_stb), .xfer_done_i(done),
        .mode_o(mode_o), .div_o(div_o), .aptr_o(aptr_o), .ival_o(ival_o),
        .shift_o(shift_o), .xfer_o(xfer_o), .berr_o(berr_o),
        .buf_we_o(buf_we_o), .buf_wdata_o(buf_wdata_o)
    );

    typedef struct {
        string      req;
        logic [7:0] rd;
        logic       x;
        logic       e;
        bit         is_buf;
    } item_t;

    item_t sb[$];

    // Monitor: compares one expected item per cycle at the falling edge
    always @(negedge clk) begin
        item_t it;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (it.is_buf) begin
                if (buf_we_o !== 1'b1 || buf_wdata_o !== it.rd) begin
                    errors++;
                    $display("FAIL %s: buf we=%0b data=%h, expected we=1 data=%h",
                             it.req, buf_we_o, buf_wdata_o, it.rd);
                end
            end else if (rd_data_o !== it.rd || xfer_o !== it.x || berr_o !== it.e) begin
                errors++;
                $display("FAIL %s: rd=%h xfer=%0b berr=%0b, expected rd=%h xfer=%0b berr=%0b",
                         it.req, rd_data_o, xfer_o, berr_o, it.rd, it.x, it.e);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic chk(input string r, input logic [2:0] a, input logic [7:0] rd,
                       input logic x, input logic e);
        item_t it;
        rd_addr = a;
        it.req = r; it.rd = rd; it.x = x; it.e = e; it.is_buf = 1'b0;
        sb.push_back(it);
        tick(1);
    endtask

    task automatic wr_buf(input string r, input logic [7:0] d);
        item_t it;
        wr_en = 1'b1; wr_addr = 3'd7; wr_data = d;
        it.req = r; it.rd = d; it.x = 1'b0; it.e = 1'b0; it.is_buf = 1'b1;
        sb.push_back(it);
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic strobe();
        bit_stb = 1'b1; tick(1); bit_stb = 1'b0;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset values
        chk("R1 mode", 3'd0, 8'h00, 1'b0, 1'b0);
        chk("R1 status", 3'd1, 8'h00, 1'b0, 1'b0);
        chk("R1 divisor", 3'd2, 8'h00, 1'b0, 1'b0);

        // R10 disabled interface ignores starts
        wr(3'd6, 8'h01);
        chk("R10 start while disabled", 3'd1, 8'h00, 1'b0, 1'b0);
        wr(3'd5, 8'h3C);
        chk("R10 shift write while disabled", 3'd5, 8'h3C, 1'b0, 1'b0);
        chk("R11 trigger reads zero", 3'd6, 8'h00, 1'b0, 1'b0);

        wr(3'd0, 8'h80);
        wr(3'd1, 8'h80);
        wr(3'd2, 8'h11);
        chk("R4 divisor unlocked write", 3'd2, 8'h11, 1'b0, 1'b0);

        // R2 start trigger
        wr(3'd6, 8'h01);
        chk("R2 R11 start sets xfer", 3'd1, 8'h81, 1'b1, 1'b0);

        // R4 lock
        wr(3'd2, 8'h22);
        chk("R4 divisor locked", 3'd2, 8'h11, 1'b1, 1'b0);
        wr(3'd0, 8'h00);
        chk("R4 mode locked", 3'd0, 8'h80, 1'b1, 1'b0);
        wr(3'd1, 8'h00);
        chk("R4 err enable locked", 3'd1, 8'h81, 1'b1, 1'b0);
        wr(3'd5, 8'h99);
        chk("R4 shift locked", 3'd5, 8'h3C, 1'b1, 1'b0);
        wr(3'd2, 8'h11);
        chk("R4 same-value write accepted", 3'd2, 8'h11, 1'b1, 1'b0);

        // R5 buffer pass-through during lock
        wr_buf("R5 buffer write while locked", 8'h5A);

        // R6 R8 error detection, level 0, busy-input-use bit left at 0
        strobe();
        chk("R6 busy not at level", 3'd1, 8'h81, 1'b1, 1'b0);
        busy = 1'b0;
        tick(1);
        strobe();
        chk("R6 busy not yet synchronized", 3'd1, 8'h81, 1'b1, 1'b0);
        strobe();
        chk("R6 R8 error detected", 3'd1, 8'h83, 1'b1, 1'b1);
        busy = 1'b1;
        tick(3);
        chk("R7 error sticky", 3'd1, 8'h83, 1'b1, 1'b1);

        // R3 stop, R7 persistence
        wr(3'd6, 8'h02);
        chk("R3 R7 stop clears xfer only", 3'd1, 8'h82, 1'b0, 1'b1);
        wr(3'd5, 8'h44);
        chk("R2 R7 shift write starts", 3'd5, 8'h44, 1'b1, 1'b1);
        done = 1'b1; tick(1); done = 1'b0;
        chk("R3 done pulse ends", 3'd1, 8'h82, 1'b0, 1'b1);
        wr(3'd6, 8'h01);
        chk("R7 start clears error", 3'd1, 8'h81, 1'b1, 1'b0);

        // R3 stop wins over start
        wr(3'd6, 8'h03);
        chk("R3 stop beats start", 3'd1, 8'h80, 1'b0, 1'b0);

        // R9 detection disabled
        wr(3'd1, 8'h00);
        wr(3'd6, 8'h01);
        busy = 1'b0;
        tick(2);
        strobe();
        chk("R9 no error when disabled", 3'd1, 8'h01, 1'b1, 1'b0);

        // R3 R7 interface disable clears both flags
        wr(3'd6, 8'h02);
        wr(3'd1, 8'h80);
        wr(3'd6, 8'h01);
        strobe();
        chk("R6 error set again", 3'd1, 8'h83, 1'b1, 1'b1);
        wr(3'd6, 8'h02);
        wr(3'd0, 8'h00);
        tick(1);
        chk("R3 R7 disable clears flags", 3'd0, 8'h00, 1'b0, 1'b0);

        finish_run();
    end
endmodule